// File: doc/BRIEF.md
# UART Receive Queue with Line Status

This block holds the characters a UART receiver hands over until software reads them back through the receive-data register. In queue mode it is a byte-wide first-in first-out store with a parameterised depth of 16 entries by default. In single-register mode only the most recent character is kept, in a holding register. It also drives the status a driver polls: occupancy, full, data-ready, a sticky error word, and a busy indication for a receive DMA engine.

The deserializer hands over a character with a one-cycle strobe. A line break arrives as a separate strobe and is stored as a zero character. The bus decoder turns register accesses into one-cycle read and write strobes. The control word selects queue mode and carries two self-clearing flush commands. Any error the block detects produces a one-cycle request for the interrupt combiner, which lies outside the block.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the status word, error word, control read-back, data-ready and the error request are all zero, and the queue is empty.
- R2: In queue mode, characters come out of the data register in the order they arrived. The occupancy appears in status bits [7:0].
- R3: With every entry in use, status bit 8 is set and status bits [7:0] read zero.
- R4: A character that arrives on a full queue, with no read in the same cycle, is discarded. It sets overrun (error bit 0) and pulses the error request in the following cycle.
- R5: A data-register read in queue mode with the queue empty returns 0x00, leaves the queue empty and pulses the error request in the following cycle.
- R6: Data-ready rises when a character is stored. It falls when a read leaves the queue empty, and stays high while entries remain.
- R7: A break strobe stores 0x00 and sets error bit 3. A character strobed in the same cycle is ignored in favour of the break.
- R8: Reading the error word returns its contents and clears it. An error raised in that same cycle is kept.
- R9: Control bit 0 selects queue mode. Writing control bit 1 empties the queue and clears data-ready, and this wins over a character stored in the same cycle. Writing bit 2 gives a one-cycle transmit-flush pulse in the following cycle. Bits 1 and 2 read back as zero, and the other bits read back as written.
- R10: The DMA-busy output is high exactly when the DMA mode input equals 2 and the queue is empty.
- R11: In single-register mode each character overwrites the holding register and sets data-ready, and the queue is left untouched. A data read returns the held byte and clears data-ready, and raises no error.
- R12: A store and a read in the same cycle leave the occupancy unchanged, including on a full queue, where the read makes room for the new character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write value |
| ctl_rdata | output | 8 | Control word read-back |
| tx_flush | output | 1 | One-cycle transmit-side flush pulse |
| dma_mode | input | 2 | Receive transfer mode; 2 selects DMA |
| rx_valid | input | 1 | Received character strobe |
| rx_byte | input | 8 | Received character |
| rx_break | input | 1 | Line break strobe |
| data_rd | input | 1 | Data register read strobe |
| data_rdata | output | 8 | Data register read value |
| err_rd | input | 1 | Error word read strobe |
| err_rdata | output | 4 | Error word (bit 0 overrun, bit 3 break) |
| stat_word | output | 9 | Occupancy [7:0], full [8] |
| data_ready | output | 1 | Receive data available |
| err_irq_req | output | 1 | One-cycle error interrupt source request |
| dma_busy | output | 1 | Receive DMA busy |

## Verification
A character store and a data-register read can land in the same cycle. The bench provokes this on a half-filled queue, on a full queue and on an empty one. A scoreboard queue fed by the driver gives the expected bytes, so order, occupancy and the absence or presence of the error request are judged together. A read of the error word is also made to coincide with a break strobe. In that cycle the bench expects the old error bits on the read, and afterwards only the break bit.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CTL_EN    = 0;
  localparam int CTL_RXCLR = 1;
  localparam int CTL_TXCLR = 2;
  localparam int ERR_OVR   = 0;
  localparam int ERR_BRK   = 3;
  localparam logic [1:0] DMA_RX_MODE = 2'b10;

  // Status word: full forces the count field to zero.
  function automatic logic [8:0] pack_status(input logic [7:0] cnt, input logic full);
    return full ? 9'h100 : {1'b0, cnt};
  endfunction

  // Control read-back drops the self-clearing command bits.
  function automatic logic [7:0] ctl_keep(input logic [7:0] wv);
    logic [7:0] r;
    r = wv;
    r[CTL_RXCLR] = 1'b0;
    r[CTL_TXCLR] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [PW-1:0] fill,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  // Pointers carry one extra wrap bit so full and empty differ.
  assign fill  = wp - rp;
  assign full  = (fill == PW'(DEPTH));
  assign empty = (fill == '0);
  assign rdata = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= PW'(DEPTH));
  // R4
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |-> !push);
  // R12
  same_cycle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !flush |=> fill == $past(fill));
  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/rxq_errlog.sv
module rxq_errlog
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_ovr,
  input  logic       set_brk,
  input  logic       rd,
  output logic [3:0] bits
);
  logic [3:0] raise;

  always_comb begin
    raise = '0;
    raise[ERR_OVR] = set_ovr;
    raise[ERR_BRK] = set_brk;
  end

  // Clear-on-read; a same-cycle new error survives.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits <= '0;
    else        bits <= (rd ? 4'h0 : bits) | raise;
  end

  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !set_ovr && !set_brk |=> bits == 4'h0);
  // R7
  break_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_brk |=> bits[ERR_BRK]);
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW   = AW + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  output logic       tx_flush,
  input  logic [1:0] dma_mode,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_break,
  input  logic       data_rd,
  output logic [7:0] data_rdata,
  input  logic       err_rd,
  output logic [3:0] err_rdata,
  output logic [8:0] stat_word,
  output logic       data_ready,
  output logic       err_irq_req,
  output logic       dma_busy
);
  logic [7:0]    ctl_q, hold_q, in_byte, head;
  logic [PW-1:0] fill;
  logic          full, empty, fifo_en;
  logic          rx_flush, arrive, pop_ev, accept_ev, drop_ev, empty_rd_ev;

  assign fifo_en     = ctl_q[CTL_EN];
  assign rx_flush    = ctl_wr && ctl_wdata[CTL_RXCLR];
  assign arrive      = rx_valid || rx_break;
  assign in_byte     = rx_break ? 8'h00 : rx_byte;
  assign pop_ev      = fifo_en && data_rd && !empty;
  assign empty_rd_ev = fifo_en && data_rd && empty;
  assign accept_ev   = fifo_en && arrive && !rx_flush && (!full || pop_ev);
  assign drop_ev     = fifo_en && arrive && !rx_flush && full && !pop_ev;

  rxq_ring #(.DEPTH(DEPTH), .W(8)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(accept_ev), .pop(pop_ev),
    .wdata(in_byte), .rdata(head), .fill(fill), .full(full), .empty(empty)
  );

  rxq_errlog u_err (
    .clk(clk), .rst_n(rst_n), .set_ovr(drop_ev), .set_brk(rx_break),
    .rd(err_rd), .bits(err_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q       <= '0;
      tx_flush    <= 1'b0;
      hold_q      <= '0;
      data_ready  <= 1'b0;
      err_irq_req <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= ctl_keep(ctl_wdata);
      tx_flush    <= ctl_wr && ctl_wdata[CTL_TXCLR];
      err_irq_req <= drop_ev || empty_rd_ev;
      if (fifo_en) begin
        if (rx_flush)                              data_ready <= 1'b0;
        else if (accept_ev)                        data_ready <= 1'b1;
        else if (pop_ev && fill == PW'(1))         data_ready <= 1'b0;
      end else begin
        if (arrive) begin
          hold_q     <= in_byte;
          data_ready <= 1'b1;
        end else if (data_rd) begin
          data_ready <= 1'b0;
        end
      end
    end
  end

  assign ctl_rdata  = ctl_q;
  assign data_rdata = fifo_en ? (empty ? 8'h00 : head) : hold_q;
  assign stat_word  = pack_status(8'(fill), full);
  assign dma_busy   = (dma_mode == DMA_RX_MODE) && empty;

  // R5
  empty_read_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && data_rd && stat_word == 9'h000 |=> err_irq_req);
  // R10
  dma_busy_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_busy |-> stat_word == 9'h000);
  // R6
  last_read_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev && fill == PW'(1) && !accept_ev && !rx_flush |=> !data_ready);
  // R9
  tx_flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush && !(ctl_wr && ctl_wdata[CTL_TXCLR]) |=> !tx_flush);
endmodule

// File: tb/uart_rx_queue_test.sv
`timescale 1ns/1ps
module uart_rx_queue_test;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 0, rx_valid = 0, rx_break = 0, data_rd = 0, err_rd = 0;
  logic [7:0] ctl_wdata = 0, rx_byte = 0;
  logic [1:0] dma_mode = 0;
  logic [7:0] ctl_rdata, data_rdata;
  logic [3:0] err_rdata;
  logic [8:0] stat_word;
  logic       tx_flush, data_ready, err_irq_req, dma_busy;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] sb_q[$];
  bit m_fifo = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_rx_queue #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .tx_flush(tx_flush), .dma_mode(dma_mode),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .data_rd(data_rd), .data_rdata(data_rdata), .err_rd(err_rd),
    .err_rdata(err_rdata), .stat_word(stat_word), .data_ready(data_ready),
    .err_irq_req(err_irq_req), .dma_busy(dma_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: compares queue-mode reads against the scoreboard.
  always @(negedge clk) begin
    #2;
    if (data_rd && m_fifo) begin
      if (sb_q.size() > 0) chk("R2 read order", data_rdata, sb_q.pop_front());
      else                 chk("R5 empty read value", data_rdata, 8'h00);
    end
  end

  // Driver: one cycle of stimulus, then scoreboard update.
  task automatic cyc(input bit v, input logic [7:0] b, input bit brk, input bit rd,
                     input bit cw, input logic [7:0] cd);
    rx_valid = v; rx_byte = b; rx_break = brk; data_rd = rd; ctl_wr = cw; ctl_wdata = cd;
    @(negedge clk);
    rx_valid = 0; rx_break = 0; data_rd = 0; ctl_wr = 0;
    if (cw && cd[1]) sb_q.delete();
    else if ((v || brk) && m_fifo && sb_q.size() < DEPTH) sb_q.push_back(brk ? 8'h00 : b);
    if (cw) m_fifo = cd[0];
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", stat_word, 9'h000);
    chk("R1 ready", data_ready, 0);
    chk("R1 errors", err_rdata, 4'h0);
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 irq", err_irq_req, 0);

    cyc(0, 0, 0, 0, 1, 8'h01);
    chk("R9 enable readback", ctl_rdata, 8'h01);

    cyc(1, 8'hA1, 0, 0, 0, 0);
    cyc(1, 8'hB2, 0, 0, 0, 0);
    cyc(1, 8'hC3, 0, 0, 0, 0);
    chk("R2 count", stat_word, 9'd3);
    chk("R6 ready set", data_ready, 1);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R6 ready stays", data_ready, 1);
    chk("R2 count after reads", stat_word, 9'd1);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R6 ready cleared", data_ready, 0);

    cyc(0, 0, 0, 1, 0, 0);
    chk("R5 error request", err_irq_req, 1);
    chk("R5 still empty", stat_word, 9'd0);

    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(8'h40 + i), 0, 0, 0, 0);
    chk("R3 full status", stat_word, 9'h100);
    chk("R5 request one cycle", err_irq_req, 0);
    cyc(1, 8'hEE, 0, 0, 0, 0);
    chk("R4 drop request", err_irq_req, 1);
    chk("R4 overrun bit", err_rdata, 4'h1);
    chk("R4 still full", stat_word, 9'h100);

    cyc(1, 8'h77, 0, 1, 0, 0);
    chk("R12 full push+pop", stat_word, 9'h100);
    chk("R12 no drop", err_irq_req, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1, 0, 0);
    chk("R2 half", stat_word, 9'd8);
    cyc(1, 8'h5A, 0, 1, 0, 0);
    chk("R12 mid push+pop", stat_word, 9'd8);

    // R8 error read coinciding with a break
    err_rd = 1; rx_break = 1;
    #2 chk("R8 read value", err_rdata, 4'h1);
    @(negedge clk);
    err_rd = 0; rx_break = 0;
    sb_q.push_back(8'h00);
    chk("R8 cleared but break kept", err_rdata, 4'h8);
    cyc(1, 8'h55, 1, 0, 0, 0);
    chk("R7 break count", stat_word, 9'd10);
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1, 0, 0);
    chk("R7 drained", stat_word, 9'd0);
    chk("R6 drained ready", data_ready, 0);

    cyc(1, 8'h01, 0, 0, 0, 0);
    cyc(1, 8'h02, 0, 0, 0, 0);
    cyc(1, 8'h03, 0, 0, 1, 8'h03);
    chk("R9 flush empties", stat_word, 9'd0);
    chk("R9 flush ready", data_ready, 0);
    chk("R9 flush bit reads 0", ctl_rdata, 8'h01);
    cyc(0, 0, 0, 0, 1, 8'h05);
    chk("R9 tx pulse", tx_flush, 1);
    chk("R9 tx bit reads 0", ctl_rdata, 8'h01);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R9 tx pulse ends", tx_flush, 0);
    cyc(0, 0, 0, 0, 1, 8'hA9);
    chk("R9 other bits", ctl_rdata, 8'hA9);

    dma_mode = 2'b10; #1;
    chk("R10 busy empty", dma_busy, 1);
    dma_mode = 2'b01; #1;
    chk("R10 other mode", dma_busy, 0);
    dma_mode = 2'b10;
    @(negedge clk);
    cyc(1, 8'h66, 0, 0, 0, 0);
    chk("R10 not empty", dma_busy, 0);

    cyc(0, 0, 0, 0, 1, 8'h00);
    cyc(1, 8'h11, 0, 0, 0, 0);
    cyc(1, 8'h22, 0, 0, 0, 0);
    chk("R11 ready", data_ready, 1);
    chk("R11 queue untouched", stat_word, 9'd1);
    data_rd = 1;
    #2 chk("R11 holding value", data_rdata, 8'h22);
    @(negedge clk);
    data_rd = 0;
    chk("R11 ready cleared", data_ready, 0);
    chk("R11 no error", err_irq_req, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule